// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a byte-wide parallel NOR flash. It turns a single request into the multi-write unlock-and-command sequence that the flash expects, then polls the device until the operation completes. Four operations are supported: byte program, sector erase, block erase and chip erase. A client places an operation code, a target address and a data byte on the request port and pulses start. It then waits for a one-cycle done pulse, with error also high if the device never settled.

Two configuration inputs adapt one sequencer to different parts. A mode bit swaps the two unlock addresses, so chips that are wired in byte mode with shifted addressing are served by the same sequence. An address mask trims the unlock addresses for small devices. For erase operations the block inserts a parameterized idle gap after every bus write, unless a zero-gap bit removes it. Completion is detected by reading the device in pairs and comparing its toggling status bit.

Top module: `nfc_cmd_seq`

## Requirements
- R1: With req_op = 0 (program), the bus writes are (U1, 0xAA), (U2, 0x55), (U1, 0xA0), then (req_addr, req_data).
- R2: With req_op = 1 (sector erase), the bus writes are (U1, 0xAA), (U2, 0x55), (U1, 0x80), (U1, 0xAA), (U2, 0x55), then (req_addr, 0x30).
- R3: With req_op = 2 (block erase), the five-write erase prefix of R2 is followed by (req_addr, 0x50).
- R4: With req_op = 3 (chip erase), the five-write erase prefix of R2 is followed by (U1, 0x10).
- R5: With cfg_shift = 0, U1 is 0x5555 and U2 is 0x2AAA. With cfg_shift = 1, U1 is 0x2AAA and U2 is 0x5555.
- R6: U1 and U2 are ANDed with cfg_addr_mask before they are driven. The target address is driven unmasked.
- R7: For erase operations, GAP_CYCLES idle cycles follow every bus write, so strobes come 3 + GAP_CYCLES cycles apart. With cfg_zero_gap = 1, or for program, strobes come 3 cycles apart.
- R8: fl_we is high for exactly one cycle per write. Address and data are stable for one cycle before and one cycle after the strobe. fl_we and fl_oe are never high together.
- R9: After the last write (and its gap), the block reads the target address in pairs, each read one fl_oe cycle. The operation ends when bit TOGGLE_BIT (6) matches across a pair. Done then pulses for one cycle, with busy low and error low.
- R10: After TIMEOUT_POLLS consecutive pairs that differ, done and error pulse together and the block returns to idle.
- R11: req_start is ignored while busy is high.
- R12: During reset, busy, done, error, fl_we and fl_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 1 | Swap unlock addresses for shifted addressing |
| cfg_zero_gap | input | 1 | Remove the inter-write gap for erase operations |
| cfg_addr_mask | input | AW | Mask ANDed onto unlock addresses |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target address |
| req_data | input | DW | Byte to program |
| req_start | input | 1 | Start pulse, sampled when idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Poll timeout, high together with done |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Flash write data |
| fl_din | input | DW | Flash read data |
| fl_we | output | 1 | Write strobe |
| fl_oe | output | 1 | Read strobe |

## Verification
Every operation code is run in both address modes. The masked runs separate unlock addresses from target addresses, because only the former may change. Erase runs are made with and without the zero-gap bit. Comparing strobe spacing tells the gapped path from the ungapped one, and the program op shows that it never gaps. The device model is made to toggle for chosen numbers of reads: zero, a few, exactly enough to finish on the last allowed pair, and one more than that. The last two separate a late completion from a timeout. A second start issued in the middle of a chip erase must leave the write stream unchanged.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_BLK  = 2'd2,
      OP_CHIP = 2'd3
   } nfc_op_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_GAP,
      ST_RDA, ST_RSP, ST_RDB, ST_RWAIT
   } nfc_state_e;

   localparam logic [15:0] UNLOCK_LO = 16'h5555;
   localparam logic [15:0] UNLOCK_HI = 16'h2AAA;

   localparam logic [7:0] CMD_KEY1   = 8'hAA;
   localparam logic [7:0] CMD_KEY2   = 8'h55;
   localparam logic [7:0] CMD_PROG   = 8'hA0;
   localparam logic [7:0] CMD_ERSET  = 8'h80;
   localparam logic [7:0] CMD_SECT   = 8'h30;
   localparam logic [7:0] CMD_BLK    = 8'h50;
   localparam logic [7:0] CMD_CHIP   = 8'h10;
endpackage

// File: rtl/nfc_down_counter.sv
module nfc_down_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (dec && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/nfc_seq_table.sv
module nfc_seq_table
   import nfc_pkg::*;
#(
   parameter int AW = 20,
   parameter int DW = 8
) (
   input  nfc_op_e       op,
   input  logic [2:0]    step,
   input  logic          shift,
   input  logic [AW-1:0] mask,
   input  logic [AW-1:0] target,
   input  logic [DW-1:0] data,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] dout,
   output logic          last
);
   localparam logic [AW-1:0] ADDR_LO = AW'(UNLOCK_LO);
   localparam logic [AW-1:0] ADDR_HI = AW'(UNLOCK_HI);

   logic [AW-1:0] u1, u2;

   // Mode bit swaps which unlock address comes first.
   assign u1 = (shift ? ADDR_HI : ADDR_LO) & mask;
   assign u2 = (shift ? ADDR_LO : ADDR_HI) & mask;

   always_comb begin
      addr = u1;
      dout = DW'(CMD_KEY1);
      last = 1'b0;
      if (op == OP_PROG) begin
         unique case (step)
            3'd0: begin addr = u1; dout = DW'(CMD_KEY1); end
            3'd1: begin addr = u2; dout = DW'(CMD_KEY2); end
            3'd2: begin addr = u1; dout = DW'(CMD_PROG); end
            default: begin addr = target; dout = data; last = 1'b1; end
         endcase
      end else begin
         unique case (step)
            3'd0: begin addr = u1; dout = DW'(CMD_KEY1); end
            3'd1: begin addr = u2; dout = DW'(CMD_KEY2); end
            3'd2: begin addr = u1; dout = DW'(CMD_ERSET); end
            3'd3: begin addr = u1; dout = DW'(CMD_KEY1); end
            3'd4: begin addr = u2; dout = DW'(CMD_KEY2); end
            default: begin
               last = 1'b1;
               unique case (op)
                  OP_SECT: begin addr = target; dout = DW'(CMD_SECT); end
                  OP_BLK:  begin addr = target; dout = DW'(CMD_BLK);  end
                  default: begin addr = u1;     dout = DW'(CMD_CHIP); end
               endcase
            end
         endcase
      end
   end
endmodule

// File: rtl/nfc_cmd_seq.sv
module nfc_cmd_seq
   import nfc_pkg::*;
#(
   parameter int AW            = 20,
   parameter int DW            = 8,
   parameter int GAP_CYCLES    = 10,
   parameter int TIMEOUT_POLLS = 1000,
   parameter int TOGGLE_BIT    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_shift,
   input  logic          cfg_zero_gap,
   input  logic [AW-1:0] cfg_addr_mask,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   input  logic          req_start,
   output logic          busy,
   output logic          done,
   output logic          error,
   output logic [AW-1:0] fl_addr,
   output logic [DW-1:0] fl_dout,
   input  logic [DW-1:0] fl_din,
   output logic          fl_we,
   output logic          fl_oe
);
   localparam bit GAP_ON = (GAP_CYCLES > 0);
   localparam int GW     = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
   localparam int TW     = (TIMEOUT_POLLS > 1) ? $clog2(TIMEOUT_POLLS) : 1;

   if (AW < 16) begin : g_chk_aw
      $error("AW must hold the 16-bit unlock addresses");
   end
   if (DW < 8) begin : g_chk_dw
      $error("DW must hold an 8-bit command byte");
   end
   if (TOGGLE_BIT >= DW) begin : g_chk_tb
      $error("TOGGLE_BIT outside data bus");
   end
   if (TIMEOUT_POLLS < 1) begin : g_chk_to
      $error("TIMEOUT_POLLS must be at least 1");
   end

   nfc_state_e    state;
   nfc_op_e       op_q;
   logic [AW-1:0] addr_q, mask_q;
   logic [DW-1:0] data_q;
   logic          shift_q, zgap_q, tog_q;
   logic [2:0]    step_q;
   logic          done_q, err_q;

   logic [AW-1:0] tbl_addr;
   logic [DW-1:0] tbl_dout;
   logic          tbl_last;
   logic          use_gap, gap_load, gap_dec, gap_zero;
   logic          to_load, to_dec, to_zero, poll_match;

   nfc_seq_table #(.AW(AW), .DW(DW)) u_table (
      .op     (op_q),
      .step   (step_q),
      .shift  (shift_q),
      .mask   (mask_q),
      .target (addr_q),
      .data   (data_q),
      .addr   (tbl_addr),
      .dout   (tbl_dout),
      .last   (tbl_last)
   );

   assign use_gap  = GAP_ON && (op_q != OP_PROG) && !zgap_q;
   assign gap_load = (state == ST_HOLD) && use_gap;
   assign gap_dec  = (state == ST_GAP);

   if (GAP_ON) begin : g_gap
      nfc_down_counter #(.W(GW)) u_gap (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (gap_load),
         .load_val (GW'(GAP_CYCLES - 1)),
         .dec      (gap_dec),
         .zero     (gap_zero)
      );
   end else begin : g_nogap
      assign gap_zero = 1'b1;
   end

   assign poll_match = (fl_din[TOGGLE_BIT] == tog_q);
   assign to_load    = (state == ST_IDLE) && req_start;
   assign to_dec     = (state == ST_RDB) && !poll_match && !to_zero;

   nfc_down_counter #(.W(TW)) u_timeout (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (to_load),
      .load_val (TW'(TIMEOUT_POLLS - 1)),
      .dec      (to_dec),
      .zero     (to_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= OP_PROG;
         addr_q  <= '0;
         mask_q  <= '0;
         data_q  <= '0;
         shift_q <= 1'b0;
         zgap_q  <= 1'b0;
         tog_q   <= 1'b0;
         step_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state)
            ST_IDLE: if (req_start) begin
               op_q    <= nfc_op_e'(req_op);
               addr_q  <= req_addr;
               data_q  <= req_data;
               mask_q  <= cfg_addr_mask;
               shift_q <= cfg_shift;
               zgap_q  <= cfg_zero_gap;
               step_q  <= '0;
               state   <= ST_SETUP;
            end
            ST_SETUP:  state <= ST_STROBE;
            ST_STROBE: state <= ST_HOLD;
            ST_HOLD: begin
               if (use_gap)
                  state <= ST_GAP;
               else if (tbl_last)
                  state <= ST_RDA;
               else begin
                  step_q <= step_q + 3'd1;
                  state  <= ST_SETUP;
               end
            end
            ST_GAP: if (gap_zero) begin
               if (tbl_last)
                  state <= ST_RDA;
               else begin
                  step_q <= step_q + 3'd1;
                  state  <= ST_SETUP;
               end
            end
            ST_RDA: begin
               tog_q <= fl_din[TOGGLE_BIT];
               state <= ST_RSP;
            end
            ST_RSP: state <= ST_RDB;
            ST_RDB: begin
               if (poll_match) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else if (to_zero) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  state  <= ST_IDLE;
               end else
                  state <= ST_RWAIT;
            end
            ST_RWAIT: state <= ST_RDA;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state != ST_IDLE);
   assign done    = done_q;
   assign error   = err_q;
   assign fl_we   = (state == ST_STROBE);
   assign fl_oe   = (state == ST_RDA) || (state == ST_RDB);
   assign fl_addr = fl_oe ? addr_q : tbl_addr;
   assign fl_dout = tbl_dout;

   // R8: the strobes never overlap
   assert_we_oe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_oe));
   // R8: the write strobe lasts a single cycle
   assert_we_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fl_we |=> !fl_we);
   // R8: address and data are held through the cycle after the strobe
   assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_we) |-> ($stable(fl_addr) && $stable(fl_dout)));
   // R8: address and data are set up one cycle before the strobe
   assert_write_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we) |-> ($stable(fl_addr) && $stable(fl_dout)));
   // R10: error only appears together with done
   assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);
   // R9: the done pulse arrives with the block idle
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R11: the latched request does not change during an operation
   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));
   // R11: a start seen while idle begins an operation
   assert_start_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_start) |=> busy);
endmodule

// File: tb/sim_nfc_cmd_seq.sv
module sim_nfc_cmd_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW  = 16;
   localparam int DW  = 8;
   localparam int GAP = 3;
   localparam int TO  = 4;
   localparam int WATCHDOG = 100000;

   typedef struct {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int            sp;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic          cfg_shift = 1'b0, cfg_zero_gap = 1'b0;
   logic [AW-1:0] cfg_addr_mask = '1;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          req_start = 1'b0;
   logic          busy, done, error, fl_we, fl_oe;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_dout, fl_din;

   always #(CLK_PERIOD/2) clk = ~clk;

   nfc_cmd_seq #(.AW(AW), .DW(DW), .GAP_CYCLES(GAP), .TIMEOUT_POLLS(TO), .TOGGLE_BIT(6)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_zero_gap(cfg_zero_gap),
      .cfg_addr_mask(cfg_addr_mask), .req_op(req_op), .req_addr(req_addr),
      .req_data(req_data), .req_start(req_start), .busy(busy), .done(done),
      .error(error), .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
      .fl_we(fl_we), .fl_oe(fl_oe)
   );

   int n_tests = 0, n_fail = 0;
   int cyc = 0;
   exp_t exp_q[$];
   string cur_tag = "R12";
   logic [AW-1:0] cur_target = '0;
   int rd_cnt = 0;
   int last_we_cyc = 0;
   logic [AW-1:0] prev_addr = '0;
   logic [DW-1:0] prev_dout = '0;
   logic [DW-1:0] din_q = 8'h12;
   int tog_left = 0;
   bit wd_hit = 1'b0;

   assign fl_din = din_q;

   // Device model: status bit 6 flips on each read while busy toggles remain.
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (fl_oe && tog_left > 0) begin
         din_q[6] <= ~din_q[6];
         tog_left <= tog_left - 1;
      end
   end

   // Monitor: pop expected writes, compare address, data, spacing and setup.
   always @(negedge clk) begin
      if (rst_n && fl_we) begin
         n_tests++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL %s: unexpected write addr %h data %h, expected none", cur_tag, fl_addr, fl_dout);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (fl_addr !== e.a || fl_dout !== e.d ||
                (e.sp != 0 && (cyc - last_we_cyc) != e.sp) ||
                prev_addr !== fl_addr || prev_dout !== fl_dout) begin
               n_fail++;
               $display("FAIL %s: write addr %h data %h spacing %0d, expected addr %h data %h spacing %0d",
                        cur_tag, fl_addr, fl_dout, cyc - last_we_cyc, e.a, e.d, e.sp);
            end
         end
         last_we_cyc = cyc;
      end
      if (rst_n && fl_oe) begin
         rd_cnt++;
         if (fl_addr !== cur_target) begin
            n_tests++; n_fail++;
            $display("FAIL %s: poll addr %h, expected %h", cur_tag, fl_addr, cur_target);
         end
      end
      prev_addr = fl_addr;
      prev_dout = fl_dout;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: got %0h, expected %0h", tag, act, expv);
      end
   endtask

   // Number of read pairs until a match; TO+1 means timeout.
   function automatic int pairs_needed(input int k);
      int left = k;
      for (int p = 1; p <= TO; p++) begin
         if (left == 0) return p;
         left--;
         if (left > 0) left--;
      end
      return TO + 1;
   endfunction

   task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input int sp);
      exp_t e;
      e.a = a; e.d = d; e.sp = sp;
      exp_q.push_back(e);
   endtask

   task automatic run_op(input string tag, input logic [1:0] op, input logic [AW-1:0] tgt,
                         input logic [DW-1:0] dat, input logic sh, input logic zg,
                         input logic [AW-1:0] msk, input int k, input bit inject);
      logic [AW-1:0] u1, u2;
      int sp, pr, exp_rd;
      bit exp_err;
      u1 = (sh ? 16'h2AAA : 16'h5555) & msk;
      u2 = (sh ? 16'h5555 : 16'h2AAA) & msk;
      sp = (op != 2'd0 && !zg) ? 3 + GAP : 3;
      if (op == 2'd0) begin
         push(u1, 8'hAA, 0); push(u2, 8'h55, sp); push(u1, 8'hA0, sp); push(tgt, dat, sp);
      end else begin
         push(u1, 8'hAA, 0); push(u2, 8'h55, sp); push(u1, 8'h80, sp);
         push(u1, 8'hAA, sp); push(u2, 8'h55, sp);
         if (op == 2'd1)      push(tgt, 8'h30, sp);
         else if (op == 2'd2) push(tgt, 8'h50, sp);
         else                 push(u1, 8'h10, sp);
      end
      pr = pairs_needed(k);
      exp_err = (pr > TO);
      exp_rd = 2 * (exp_err ? TO : pr);
      @(negedge clk);
      cur_tag = tag; cur_target = tgt; rd_cnt = 0; tog_left = k;
      req_op = op; req_addr = tgt; req_data = dat;
      cfg_shift = sh; cfg_zero_gap = zg; cfg_addr_mask = msk;
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      check({tag, " busy after start"}, busy, 1'b1);
      if (inject) begin
         // R11: a second request while busy must not disturb the sequence
         repeat (5) @(negedge clk);
         req_op = 2'd0; req_addr = 16'h0F0F; req_data = 8'hEE; req_start = 1'b1;
         @(negedge clk);
         req_start = 1'b0;
      end
      while (!done && cyc < WATCHDOG) @(negedge clk);
      if (cyc >= WATCHDOG) begin
         wd_hit = 1'b1;
         return;
      end
      check({tag, " error flag"}, error, exp_err);
      check({tag, " busy at done"}, busy, 1'b0);
      check({tag, " poll reads"}, rd_cnt, exp_rd);
      check({tag, " writes left"}, exp_q.size(), 0);
      exp_q.delete();
      @(negedge clk);
      check({tag, " done one cycle"}, done, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset values
      check("R12 busy", busy, 1'b0);
      check("R12 done", done, 1'b0);
      check("R12 error", error, 1'b0);
      check("R12 strobes", {fl_we, fl_oe}, 2'b00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 R5 R9: program, normal addressing, device ready at once
      if (!wd_hit) run_op("R1", 2'd0, 16'h1234, 8'h5A, 1'b0, 1'b0, 16'hFFFF, 0, 1'b0);
      // R5 R9: program, shifted addressing, device busy for a few reads
      if (!wd_hit) run_op("R5", 2'd0, 16'h00FE, 8'hC3, 1'b1, 1'b0, 16'hFFFF, 3, 1'b0);
      // R2 R7: sector erase with gaps
      if (!wd_hit) run_op("R2", 2'd1, 16'h4000, 8'h00, 1'b0, 1'b0, 16'hFFFF, 2, 1'b0);
      // R3 R7: block erase, shifted, gaps removed
      if (!wd_hit) run_op("R3", 2'd2, 16'h8000, 8'h00, 1'b1, 1'b1, 16'hFFFF, 1, 1'b0);
      // R4 R6: chip erase with a narrow mask on unlock addresses
      if (!wd_hit) run_op("R4", 2'd3, 16'h0000, 8'h00, 1'b0, 1'b0, 16'h0F0F, 0, 1'b0);
      // R6: target address stays unmasked
      if (!wd_hit) run_op("R6", 2'd1, 16'hFFFF, 8'h00, 1'b1, 1'b1, 16'h3FFF, 0, 1'b0);
      // R7: zero-gap sector erase keeps program spacing
      if (!wd_hit) run_op("R7", 2'd1, 16'h2000, 8'h00, 1'b0, 1'b1, 16'hFFFF, 0, 1'b0);
      // R10: finishes on the last allowed pair
      if (!wd_hit) run_op("R10", 2'd0, 16'h0100, 8'h77, 1'b0, 1'b0, 16'hFFFF, 6, 1'b0);
      // R10: one more toggle forces a timeout
      if (!wd_hit) run_op("R10", 2'd0, 16'h0101, 8'h88, 1'b0, 1'b0, 16'hFFFF, 7, 1'b0);
      // R11: start pulsed during a chip erase
      if (!wd_hit) run_op("R11", 2'd3, 16'h0000, 8'h00, 1'b1, 1'b0, 16'hFFFF, 2, 1'b1);
      if (wd_hit) begin
         n_tests++; n_fail++;
         $display("FAIL %s: watchdog expired, got no done, expected done", cur_tag);
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule